// File: doc/BRIEF.md
# Bus-Kicked Watchdog Reset Generator

This block is a reset supervisor with a single reset output. It keeps the output active from power-up, and again whenever a digital supply-good flag drops. It lets go only after the flag has stayed high for a fixed hold time. It also runs a watchdog timer. The watchdog is restarted by bus activity on a two-wire serial bus and not by a dedicated kick pin. A restart is a start condition (SDA falls while SCL is high) followed later by a stop condition (SDA rises while SCL is high).

A 2-bit code selects the watchdog period: long, medium, short or off. If the watchdog is enabled and no restart arrives within the period, the output goes active for a fixed pulse time. The watchdog counter is held at zero while reset is active, so every timing window starts at the release. The polarity of the output is chosen at build time. All times are given in milliseconds and converted to clocks by a clocks-per-millisecond parameter, so a bench can use short windows.

Top module: `bus_watchdog_supervisor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the reset output is active.
- R2: The output releases on the HOLD_MS*CLKS_PER_MS-th consecutive clock edge that samples `supply_ok` high (provided no watchdog pulse is running), and not one edge earlier.
- R3: Any edge that samples `supply_ok` low makes the output active after that edge and restarts the hold count from zero.
- R4: `period_code` 2'b10 selects SHORT_MS, 2'b01 selects MID_MS and 2'b00 selects LONG_MS. With no restart, the output goes active exactly period*CLKS_PER_MS edges after the release edge.
- R5: `period_code` 2'b11 disables the watchdog: the output never goes active from a timeout.
- R6: A start followed by a stop restarts the watchdog count from zero. The count is cleared on the third edge after the first edge that samples (through two synchronising flops) the stop's SDA rise.
- R7: A stop with no start since the previous restart does not restart the watchdog. SDA edges while SCL is low are neither start nor stop.
- R8: A watchdog expiry holds the output active for exactly PULSE_MS*CLKS_PER_MS cycles.
- R9: The watchdog count is held at zero while the output is active. A full period is counted after each release, including a release that ends a watchdog pulse.
- R10: A restart that lands on the same edge as the expiry wins: no pulse is produced.
- R11: A supply drop during a watchdog pulse extends reset until both the pulse has ended and the full hold time has passed since the supply returned.
- R12: With ACTIVE_LOW=1 the active level of `reset_out` is 0; with ACTIVE_LOW=0 it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| supply_ok | input | 1 | High while the supply is above its trip level |
| period_code | input | 2 | Watchdog period select (00 long, 01 medium, 10 short, 11 off) |
| reset_out | output | 1 | Registered reset output, polarity set by ACTIVE_LOW |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a bus restart and a watchdog expiry land on the same edge. The bench times the stop's SDA rise so that the restart reaches the counter exactly on the edge where expiry would occur, and judges that no pulse follows within the next few cycles. In the second, a supply drop lands inside a watchdog pulse. The bench pulls `supply_ok` low during the pulse and judges that the release waits for the full hold time after the supply returns, not for the pulse to end. A behavioural reference model is compared with the output on every clock. A second instance with the opposite polarity is compared with the first on every clock.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } per_code_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/bw_bus_monitor.sv
module bw_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic kick
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, armed;
  logic scl_now, sda_now, start_seen, stop_seen;

  assign scl_now = scl_sync[SYNC_STAGES-1];
  assign sda_now = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_now;
      sda_d    <= sda_now;
    end
  end

  // conditions are recognised only while SCL stays high across the SDA edge
  assign start_seen = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_seen  = scl_now & scl_d & ~sda_d & sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      kick  <= 1'b0;
    end else begin
      kick <= stop_seen & armed;
      if (start_seen)     armed <= 1'b1;
      else if (stop_seen) armed <= 1'b0;
    end
  end

  // R7: a restart pulse needs an armed start beforehand
  a_r7_kick_needs_start: assert property (@(posedge clk) disable iff (rst)
    kick |-> $past(armed));
  // R6: one restart pulse per stop
  a_r6_kick_single: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick);
endmodule

// File: rtl/bw_watchdog.sv
module bw_watchdog
  import bw_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int LONG_MS     = 1400,
  parameter int MID_MS      = 600,
  parameter int SHORT_MS    = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       kick,
  input  logic [1:0] period_code,
  output logic       fire
);
  localparam int LONG_CLKS  = LONG_MS * CLKS_PER_MS;
  localparam int MID_CLKS   = MID_MS * CLKS_PER_MS;
  localparam int SHORT_CLKS = SHORT_MS * CLKS_PER_MS;
  localparam int CW         = cnt_width(LONG_CLKS);

  logic [CW-1:0] cnt, limit_m1;
  logic          enabled;

  always_comb begin
    enabled  = 1'b1;
    limit_m1 = CW'(SHORT_CLKS - 1);
    case (per_code_t'(period_code))
      PER_LONG:  limit_m1 = CW'(LONG_CLKS - 1);
      PER_MID:   limit_m1 = CW'(MID_CLKS - 1);
      PER_SHORT: limit_m1 = CW'(SHORT_CLKS - 1);
      default:   enabled  = 1'b0;
    endcase
  end

  // a restart on the expiry edge suppresses the expiry
  assign fire = enabled & ~hold & ~kick & (cnt >= limit_m1);

  always_ff @(posedge clk) begin
    if (rst || hold || !enabled || kick || fire) cnt <= '0;
    else                                         cnt <= cnt + 1'b1;
  end

  // R9: no counting while reset is active
  a_r9_held_in_reset: assert property (@(posedge clk) disable iff (rst)
    hold |=> cnt == '0);
  // R5: off setting never expires
  a_r5_off_silent: assert property (@(posedge clk) disable iff (rst)
    (period_code == 2'b11) |-> !fire);
  // R6: a restart clears the count
  a_r6_kick_restarts: assert property (@(posedge clk) disable iff (rst)
    kick |=> cnt == '0);
endmodule

// File: rtl/bw_reset_ctrl.sv
module bw_reset_ctrl
  import bw_pkg::*;
#(
  parameter int HOLD_CLKS  = 20000000,
  parameter int PULSE_CLKS = 20000000,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic wd_fire,
  output logic active,
  output logic reset_pin
);
  localparam int HW = cnt_width(HOLD_CLKS);
  localparam int PW = cnt_width(PULSE_CLKS);

  logic [HW-1:0] sup_cnt, sup_nxt;
  logic [PW-1:0] pulse_cnt, pulse_nxt;
  logic          act_nxt;

  always_comb begin
    sup_nxt = sup_cnt;
    if (!supply_ok)                sup_nxt = '0;
    else if (sup_cnt != HW'(HOLD_CLKS)) sup_nxt = sup_cnt + 1'b1;
    pulse_nxt = '0;
    if (wd_fire)             pulse_nxt = PW'(PULSE_CLKS);
    else if (pulse_cnt != 0) pulse_nxt = pulse_cnt - 1'b1;
    act_nxt = (sup_nxt != HW'(HOLD_CLKS)) || (pulse_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_cnt   <= '0;
      pulse_cnt <= '0;
      active    <= 1'b1;
    end else begin
      sup_cnt   <= sup_nxt;
      pulse_cnt <= pulse_nxt;
      active    <= act_nxt;
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) reset_pin <= 1'b0;
        else     reset_pin <= ~act_nxt;
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) reset_pin <= 1'b1;
        else     reset_pin <= act_nxt;
      end
    end
  endgenerate

  // R3: a supply drop asserts reset on the next cycle
  a_r3_drop_asserts: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> active);
  // R8: an expiry starts a full pulse
  a_r8_fire_pulses: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> active && (pulse_cnt == PW'(PULSE_CLKS)));
  // R2: release only once the hold time has been met
  a_r2_release_after_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (sup_cnt == HW'(HOLD_CLKS)) && $past(supply_ok));
endmodule

// File: rtl/bus_watchdog_supervisor.sv
module bus_watchdog_supervisor #(
  parameter int CLKS_PER_MS = 100000,
  parameter int HOLD_MS     = 200,
  parameter int PULSE_MS    = 200,
  parameter int LONG_MS     = 1400,
  parameter int MID_MS      = 600,
  parameter int SHORT_MS    = 200,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       supply_ok,
  input  logic [1:0] period_code,
  output logic       reset_out
);
  localparam int HOLD_CLKS  = HOLD_MS * CLKS_PER_MS;
  localparam int PULSE_CLKS = PULSE_MS * CLKS_PER_MS;

  logic kick, fire, rst_active;

  bw_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .kick(kick)
  );

  bw_watchdog #(
    .CLKS_PER_MS(CLKS_PER_MS), .LONG_MS(LONG_MS),
    .MID_MS(MID_MS), .SHORT_MS(SHORT_MS)
  ) u_wd (
    .clk(clk), .rst(rst), .hold(rst_active), .kick(kick),
    .period_code(period_code), .fire(fire)
  );

  bw_reset_ctrl #(
    .HOLD_CLKS(HOLD_CLKS), .PULSE_CLKS(PULSE_CLKS), .ACTIVE_LOW(ACTIVE_LOW)
  ) u_rc (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_fire(fire),
    .active(rst_active), .reset_pin(reset_out)
  );
endmodule

// File: tb/tb_bus_watchdog_supervisor.sv
`timescale 1ns/1ps
module tb_bus_watchdog_supervisor;
  localparam int CPM   = 2;
  localparam int HOLD  = 10 * CPM;
  localparam int PULSE = 6 * CPM;
  localparam int LONG  = 40 * CPM;
  localparam int MID   = 25 * CPM;
  localparam int SHORT = 15 * CPM;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1, ok = 1'b0;
  logic [1:0] code = 2'b11;
  logic pin_lo, pin_hi;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_watchdog_supervisor #(.CLKS_PER_MS(CPM), .HOLD_MS(10), .PULSE_MS(6),
    .LONG_MS(40), .MID_MS(25), .SHORT_MS(15), .ACTIVE_LOW(1'b1)) dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .supply_ok(ok),
    .period_code(code), .reset_out(pin_lo));

  bus_watchdog_supervisor #(.CLKS_PER_MS(CPM), .HOLD_MS(10), .PULSE_MS(6),
    .LONG_MS(40), .MID_MS(25), .SHORT_MS(15), .ACTIVE_LOW(1'b0)) dut_hi (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .supply_ok(ok),
    .period_code(code), .reset_out(pin_hi));

  // behavioural reference model
  int m_sup, m_pulse, m_wd;
  bit m_act = 1'b1, m_armed, m_kick;
  bit [1:0] hist[$];

  always @(posedge clk) begin
    bit [1:0] cur, prv;
    bit st, sp, en, fire, kick_now;
    int lim;
    cyc++;
    if (rst) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_sup = 0; m_pulse = 0; m_wd = 0; m_act = 1'b1; m_armed = 1'b0; m_kick = 1'b0;
    end else begin
      hist.push_back({scl, sda});
      while (hist.size() > 4) void'(hist.pop_front());
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      case (code)
        2'b00: lim = LONG;
        2'b01: lim = MID;
        2'b10: lim = SHORT;
        default: lim = 0;
      endcase
      en = (code != 2'b11);
      fire = en && !m_act && !m_kick && (m_wd >= lim - 1);
      kick_now = m_kick;
      st = cur[1] && prv[1] && prv[0] && !cur[0];
      sp = cur[1] && prv[1] && !prv[0] && cur[0];
      m_kick = sp && m_armed;
      if (st) m_armed = 1'b1; else if (sp) m_armed = 1'b0;
      m_wd = (m_act || !en || kick_now || fire) ? 0 : m_wd + 1;
      m_sup = !ok ? 0 : ((m_sup < HOLD) ? m_sup + 1 : m_sup);
      m_pulse = fire ? PULSE : ((m_pulse > 0) ? m_pulse - 1 : 0);
      m_act = (m_sup != HOLD) || (m_pulse != 0);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  // every-clock comparison against the model and between polarities
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("model", ~pin_lo, m_act);
      chk("R12 polarity", pin_hi, ~pin_lo);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(bit want);
    int n = 0;
    while ((~pin_lo) !== want && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic bus_kick();
    sda = 1'b0; step(3);
    scl = 1'b0; step(3);
    scl = 1'b1; step(3);
    sda = 1'b1; step(6);
  endtask

  // stop conditions without a start, plus SDA toggles while SCL is low
  task automatic bus_junk();
    scl = 1'b0; sda = 1'b0; step(2);
    sda = 1'b1; step(2);
    sda = 1'b0; step(2);
    scl = 1'b1; step(2);
    sda = 1'b1; step(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit saw;
    step(5);
    chk("R1 active in reset", ~pin_lo, 1'b1);
    chk("R12 active-high pin in reset", pin_hi, 1'b1);
    rst = 1'b0;
    step(1);
    chk("R1 active after reset", ~pin_lo, 1'b1);
    step(29);
    chk("R3 supply low keeps reset", ~pin_lo, 1'b1);

    ok = 1'b1;
    step(HOLD - 1);
    chk("R2 one edge before hold", ~pin_lo, 1'b1);
    step(1);
    chk("R2 release at hold", ~pin_lo, 1'b0);
    chk("R12 pin levels released", pin_lo & ~pin_hi, 1'b1);

    step(200);
    chk("R5 off never expires", ~pin_lo, 1'b0);

    ok = 1'b0; step(1);
    chk("R3 glitch asserts", ~pin_lo, 1'b1);
    ok = 1'b1; step(HOLD - 1);
    chk("R3 hold count restarted", ~pin_lo, 1'b1);
    step(1);
    chk("R3 release after new hold", ~pin_lo, 1'b0);

    code = 2'b10;
    step(SHORT - 1);
    chk("R4 short not yet", ~pin_lo, 1'b0);
    step(1);
    chk("R4 short expiry", ~pin_lo, 1'b1);
    step(PULSE - 1);
    chk("R8 pulse still active", ~pin_lo, 1'b1);
    step(1);
    chk("R8 pulse length", ~pin_lo, 1'b0);
    step(SHORT - 1);
    chk("R9 full period after pulse", ~pin_lo, 1'b0);
    step(1);
    chk("R9 expiry after pulse", ~pin_lo, 1'b1);

    wait_for(1'b0);
    for (int i = 0; i < 5; i++) begin
      bus_kick();
      step(5);
      chk("R6 restart keeps reset off", ~pin_lo, 1'b0);
    end

    saw = 0;
    for (int i = 0; i < 4; i++) begin
      bus_junk();
      if (~pin_lo) saw = 1;
    end
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (~pin_lo) saw = 1;
    end
    chk("R7 stop without start ignored", saw, 1'b1);

    wait_for(1'b1);
    wait_for(1'b0);
    sda = 1'b0; step(3);
    scl = 1'b0; step(3);
    scl = 1'b1; step(3);
    step(SHORT - 4 - 9);
    sda = 1'b1;
    step(SHORT + 5 - (SHORT - 4));
    chk("R10 restart on expiry edge wins", ~pin_lo, 1'b0);

    wait_for(1'b1);
    code = 2'b01;
    wait_for(1'b0);
    step(MID - 1);
    chk("R4 medium not yet", ~pin_lo, 1'b0);
    step(1);
    chk("R4 medium expiry", ~pin_lo, 1'b1);
    code = 2'b00;
    wait_for(1'b0);
    step(LONG - 1);
    chk("R4 long not yet", ~pin_lo, 1'b0);
    step(1);
    chk("R4 long expiry", ~pin_lo, 1'b1);
    code = 2'b11;
    wait_for(1'b0);
    step(200);
    chk("R5 off after switch", ~pin_lo, 1'b0);

    code = 2'b10;
    wait_for(1'b1);
    step(3); ok = 1'b0;
    step(2); ok = 1'b1;
    step(9);
    chk("R11 pulse extended by supply loss", ~pin_lo, 1'b1);
    step(10);
    chk("R11 one edge before hold", ~pin_lo, 1'b1);
    step(1);
    chk("R11 release after hold", ~pin_lo, 1'b0);

    step(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule